// File: doc/BRIEF.md
# DMA Task Interrupt Aggregator

This block collects completion events from sixteen DMA tasks and folds them into one interrupt request. That request serves as source number 0 of the peripheral interrupt group. Each task has a pending flag and an enable-inhibit flag. Software reaches both through a small register port. A pending flag is cleared by writing a 1 to its bit position.

The block also decodes which task to service next. This is the lowest-numbered task whose pending flag is set. The decoder presents it as an interrupt vector in a separate virtual group. The group code 3 occupies vector bits 7:6 and the task number occupies bits 5:0. An interrupt dispatcher can therefore hand each task its own handler, even though the hardware raises only one line.

The register port is a plain single-cycle control interface. It has no handshake and no back-pressure: a write takes effect on the clock edge where `reg_wr` is high, and `reg_rdata` always shows the register selected by `reg_addr`. The decoded vector is a level status, not a stream. It stays valid for as long as any task is pending, and it is consumed only by clearing the pending bit. For that reason it has a valid flag but no ready input.

Top module: `dti_aggregator`

## Requirements
- R1: After reset, every pending bit reads 0 and every mask bit reads 1 (the mask register at address 1 reads 0x0000FFFF), with `irq_out` and `vec_valid` low.
- R2: An event on `task_evt[n]` sets pending bit n at the next clock edge, whether or not task n is masked; bit n of the pending register at address 0 belongs to task n.
- R3: A write to address 0 clears every pending bit whose write-data bit is 1, leaves bits written 0 unchanged, and 0xFFFFFFFF clears all sixteen.
- R4: When an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: A write to address 1 loads the mask; mask bit n set to 1 disables task n; bits 31:16 of both registers read as 0 and are not stored.
- R6: `irq_out` is high exactly when at least one pending bit has its mask bit at 0.
- R7: `vec_valid` is high exactly when any pending bit is set; `vec_out` is then 0xC0 plus the index of the lowest-numbered pending task, and 0x00 otherwise.
- R8: The mask does not affect the decoder: a masked pending task still appears in `vec_out` if it is the lowest-numbered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| task_evt | input | 16 | One-cycle event pulse per DMA task |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 pending, 1 mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq_out | output | 1 | Aggregated request, peripheral source 0 |
| vec_valid | output | 1 | A task is pending and `vec_out` is meaningful |
| vec_out | output | 8 | Decoded vector: group in 7:6, task in 5:0 |

## Verification
The embedded properties check the following on every cycle:
- an event always lands in its pending bit, including against a simultaneous clear;
- a clear without a competing event removes the bit;
- no pending bit appears without an event;
- the mask changes only on a write to it;
- the vector carries the virtual group code and points at a pending task with no lower pending task.

Some behaviours are visible only through the bench scenarios:
- the reset values as seen through the register port;
- the truncation of the upper data bits;
- the exact on/off relation between mask, pending and `irq_out` across sequences;
- the claim that masking leaves the decoded vector unchanged.

// File: rtl/dti_pkg.sv
package dti_pkg;
  typedef enum logic {
    SEL_PEND = 1'b0,
    SEL_MASK = 1'b1
  } dti_sel_e;

  localparam int unsigned DTI_GROUP_CODE = 3;
endpackage

// File: rtl/dti_pend_bank.sv
module dti_pend_bank #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= evt[i] | (pend_q[i] & ~clr[i]);
    end
  end

  assign pend = pend_q;

  // R2: an event always lands in its pending bit
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

  // R2: no bit rises without an event
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(evt)) == '0));

  // R3: a clear with no competing event drops the bit
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~evt) != '0) |=> ((pend & $past(clr & ~evt)) == '0));

  // R4: event beats clear in the same cycle
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & evt) != '0) |=> ((pend & $past(clr & evt)) == $past(clr & evt)));
endmodule

// File: rtl/dti_mask_reg.sv
module dti_mask_reg #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '1;
    else if (we) mask_q <= wdata;
  end

  assign mask = mask_q;

  // R5: the mask changes only when written
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mask));

  // R5: a write loads the data
  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mask == $past(wdata)));
endmodule

// File: rtl/dti_ffs.sv
module dti_ffs #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 6
) (
  input  logic [N-1:0]     bits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |bits;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dti_aggregator.sv
module dti_aggregator #(
  parameter int unsigned NUM_TASKS = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_W     = 6,
  parameter int unsigned GRP_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_TASKS-1:0]   task_evt,
  input  logic                   reg_wr,
  input  logic                   reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  output logic                   irq_out,
  output logic                   vec_valid,
  output logic [GRP_W+IDX_W-1:0] vec_out
);
  import dti_pkg::*;

  localparam int unsigned VEC_W = GRP_W + IDX_W;
  localparam logic [GRP_W-1:0] GRP = GRP_W'(DTI_GROUP_CODE);

  logic [NUM_TASKS-1:0] pend;
  logic [NUM_TASKS-1:0] mask;
  logic [NUM_TASKS-1:0] clr;
  logic                 mask_we;
  logic                 found;
  logic [IDX_W-1:0]     idx;

  assign clr     = (reg_wr && (reg_addr == SEL_PEND)) ? reg_wdata[NUM_TASKS-1:0] : '0;
  assign mask_we = reg_wr && (reg_addr == SEL_MASK);

  dti_pend_bank #(.N(NUM_TASKS)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(task_evt), .clr(clr), .pend(pend));

  dti_mask_reg #(.N(NUM_TASKS)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we),
    .wdata(reg_wdata[NUM_TASKS-1:0]), .mask(mask));

  dti_ffs #(.N(NUM_TASKS), .IDX_W(IDX_W)) u_ffs (
    .bits(pend), .found(found), .idx(idx));

  always_comb begin
    reg_rdata = '0;
    reg_rdata[NUM_TASKS-1:0] = (reg_addr == SEL_MASK) ? mask : pend;
  end

  assign irq_out   = |(pend & ~mask);
  assign vec_valid = found;
  assign vec_out   = found ? {GRP, idx} : '0;

  // R6: a request implies some pending task
  p_irq_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> vec_valid);

  // R7: the vector carries the virtual group code
  p_vec_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_out[VEC_W-1:IDX_W] == GRP));

  // R7: the vector points at a pending task
  p_vec_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> pend[vec_out[IDX_W-1:0]]);

  // R7: no lower-numbered task is pending
  p_vec_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ((pend & ((NUM_TASKS'(1) << vec_out[IDX_W-1:0]) - NUM_TASKS'(1))) == '0));
endmodule

// File: tb/sim_dti_aggregator.sv
module sim_dti_aggregator;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        irq;
    logic        vv;
    logic [7:0]  vec;
    logic [31:0] rd;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] task_evt = '0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;
  logic        vec_valid;
  logic [7:0]  vec_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];
  event  chk_ev;

  logic [15:0] m_pend = '0;
  logic [15:0] m_mask = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dti_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .task_evt(task_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .vec_valid(vec_valid), .vec_out(vec_out));

  function automatic exp_t model_out(logic a);
    exp_t e;
    e.irq = |(m_pend & ~m_mask);
    e.vv  = |m_pend;
    e.vec = 8'h00;
    for (int i = 15; i >= 0; i--) if (m_pend[i]) e.vec = 8'hC0 | 8'(i);
    e.rd  = a ? {16'h0, m_mask} : {16'h0, m_pend};
    return e;
  endfunction

  task automatic step(input logic [15:0] evt, input logic wr, input logic a,
                      input logic [31:0] wd, input string tag);
    @(negedge clk);
    task_evt = evt; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    #1;
    if (wr && !a) m_pend = m_pend & ~wd[15:0];
    m_pend = m_pend | evt;
    if (wr && a)  m_mask = wd[15:0];
    exp_q.push_back(model_out(a));
    tag_q.push_back(tag);
    ->chk_ev;
    @(negedge clk);
    task_evt = '0; reg_wr = 1'b0;
  endtask

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(chk_ev);
      begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        cmp(t, "irq_out",   32'(irq_out),   32'(e.irq));
        cmp(t, "vec_valid", 32'(vec_valid), 32'(e.vv));
        cmp(t, "vec_out",   32'(vec_out),   32'(e.vec));
        cmp(t, "reg_rdata", reg_rdata,      e.rd);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(16'h0000, 1'b0, 1'b1, 32'h0, "R1");          // mask resets to all ones
    step(16'h0000, 1'b0, 1'b0, 32'h0, "R1");          // pending resets to zero
    step(16'h0020, 1'b0, 1'b0, 32'h0, "R2/R8");       // masked task 5 still pends and decodes
    step(16'h0000, 1'b1, 1'b1, 32'h0000FFDF, "R5/R6"); // unmask 5 -> request
    step(16'h1008, 1'b0, 1'b0, 32'h0, "R7");          // tasks 3,12 -> vector 0xC3
    step(16'h0000, 1'b1, 1'b0, 32'h00000008, "R3");   // clear task 3 only
    step(16'h0020, 1'b1, 1'b0, 32'h00000020, "R4");   // set beats clear
    step(16'h0000, 1'b1, 1'b0, 32'h00000020, "R6");   // only masked 12 left -> no irq
    step(16'h8000, 1'b0, 1'b0, 32'h0, "R8");          // masked 12 decodes first
    step(16'h0000, 1'b1, 1'b0, 32'hFFFFFFFF, "R3");   // clear all
    step(16'h0001, 1'b0, 1'b0, 32'h0, "R7");          // task 0 boundary -> 0xC0
    step(16'h0000, 1'b1, 1'b1, 32'hFFFF0000, "R5");   // upper bits dropped, all unmasked
    step(16'hFFFF, 1'b0, 1'b0, 32'h0, "R2");          // all tasks pend
    step(16'h0000, 1'b1, 1'b0, 32'h00007FFF, "R7");   // only 15 left -> 0xCF
    step(16'h0000, 1'b1, 1'b0, 32'h0000FFFF, "R3");
    for (int k = 0; k < 16; k++) begin
      step(16'(1) << k, 1'b0, 1'b0, 32'h0, "R7");
      step(16'h0000, 1'b1, 1'b0, 32'h1 << k, "R3");
    end
    step(16'h0000, 1'b1, 1'b1, 32'h0000AAAA, "R5");
    step(16'h0006, 1'b0, 1'b1, 32'h0, "R6");          // task 2 unmasked -> irq
    step(16'h0000, 1'b1, 1'b0, 32'h00000004, "R6");   // task 1 masked only -> irq low
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule